// File: doc/BRIEF.md
# UNIBUS Master Transfer Sequencer with Acquisition and Slave Watchdogs

This block sits on the UNIBUS side of a system-bus-to-UNIBUS adapter. It runs one bus data transfer for each upstream read or write request. After it accepts a request, it asks for bus mastership. It takes the bus only when the grant is present and the previous slave has dropped both SSYN and BBSY. It then drives address and control for one setup cycle and runs the MSYN/SSYN handshake. When the handshake ends, it returns a one-cycle response upstream.

Two watchdogs bound the waits, and each counts ticks derived from the system clock.

- **Acquisition watchdog.** It limits the wait for mastership to 256 ticks.
- **Slave watchdog.** It limits the time MSYN may stay up without SSYN to 64 ticks.

With a 200 ns tick, the worst case is 320 ticks, or 64 us. This is well inside a 102.4 us upstream data window.

When either watchdog expires, the request completes with all-zero data and a timeout marker. Each watchdog also sets its own sticky status flag. The acquisition flag can raise an interrupt.

Top module: `ub_master_ctl`

## Requirements
- R1: After a synchronous reset, bus_req, bbsy_out, msyn_out, rsp_valid, irq, sel_to_flag and ssyn_to_flag are all 0, and req_ready is 1.
- R2: While a request waits for mastership, bus_req stays 1. bbsy_out rises only on the cycle after one in which bus_grant is 1 and both ssyn_in and bbsy_in are 0.
- R3: msyn_out is high only while bbsy_out is high. Before msyn_out rises, bbsy_out and the request's address on addr_out have already been stable for at least one clock.
- R4: On a read, the cycle after ssyn_in is seen high while msyn_out is high, msyn_out and bbsy_out are 0. In that same cycle rsp_valid pulses for one clock, with rsp_rdata equal to the bus_din captured and rsp_timeout 0.
- R5: On a write, wr_out and bus_dout_en are 1 while msyn_out is 1, and bus_dout carries the request's write data. The response carries rsp_rdata 0 and rsp_timeout 0.
- R6: If mastership is not taken within SEL_TICKS×CLK_PER_TICK clocks (default 5120), bus_req is high for exactly that many cycles. bbsy_out never rises. The request completes with rsp_rdata 0 and rsp_timeout 1, and sel_to_flag is 1 in the response cycle.
- R7: If SSYN does not answer, msyn_out stays high for exactly SSYN_TICKS×CLK_PER_TICK clocks (default 1280). In the next cycle msyn_out and bbsy_out are 0, and the request completes with rsp_rdata 0 and rsp_timeout 1. ssyn_to_flag is then 1 and sel_to_flag is unchanged.
- R8: irq is 1 exactly when sel_to_flag is 1 and sel_ie is 1. ssyn_to_flag never raises irq.
- R9: Each flag is cleared by a one-cycle pulse on its own clear input, visible the next cycle. The other flag is left as it was.
- R10: bus_init aborts any transfer: the next cycle has msyn_out, bbsy_out and bus_req at 0 and req_ready at 1. No response is issued and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_init | input | 1 | Bus reset; aborts the transfer in progress |
| req_valid | input | 1 | Upstream request present (taken when req_ready is 1) |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, zero on write or timeout |
| rsp_timeout | output | 1 | Completion caused by a watchdog expiry |
| bus_req | output | 1 | Mastership request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| bbsy_in | input | 1 | Bus busy held by another master |
| ssyn_in | input | 1 | Slave sync |
| bus_din | input | DATA_W | Data lines as received |
| bbsy_out | output | 1 | Bus busy driven by this master |
| msyn_out | output | 1 | Master sync |
| wr_out | output | 1 | Transfer direction on the control lines |
| addr_out | output | ADDR_W | Address lines |
| bus_dout | output | DATA_W | Data lines driven on a write |
| bus_dout_en | output | 1 | Enable for bus_dout |
| sel_ie | input | 1 | Interrupt enable for the acquisition-timeout flag |
| clr_sel_flag | input | 1 | Write-one-to-clear strobe for sel_to_flag |
| clr_ssyn_flag | input | 1 | Write-one-to-clear strobe for ssyn_to_flag |
| sel_to_flag | output | 1 | Sticky acquisition-timeout status |
| ssyn_to_flag | output | 1 | Sticky slave-response-timeout status |
| irq | output | 1 | Interrupt request |

## Verification
**Stuck slave.** The central corner case is a slave that keeps holding SSYN after its cycle. The bench checks that the sequencer keeps requesting for exactly 5120 clocks, never takes the bus, and then completes with zero data. A design that ignored SSYN when taking the bus would collide with the slave. A design with no acquisition watchdog would hang.

**Silent slave.** The bench counts the MSYN-high window cycle by cycle. An off-by-one in the tick prescaler or the tick counter shows up as a window of the wrong length.

**Another master busy.** The bench holds another master's BBSY and checks that the block does not seize the bus.

**Abort and status.** A bus reset arriving during MSYN must drop the handshake without producing a completion or a flag. The bench also confirms that clearing one status flag leaves the other intact. It confirms that only the acquisition flag reaches the interrupt line.

// File: rtl/ub_master_pkg.sv
package ub_master_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARB   = 3'd1,
    ST_SETUP = 3'd2,
    ST_MSYN  = 3'd3,
    ST_DONE  = 3'd4,
    ST_TOUT  = 3'd5
  } ub_state_e;

  // index of each watchdog in the watchdog array
  localparam int WD_SEL  = 0;
  localparam int WD_SSYN = 1;
  localparam int WD_NUM  = 2;

endpackage

// File: rtl/ub_wdog.sv
// Tick-counting watchdog: a prescaler derives ticks from the clock while
// run is high; expire pulses in the cycle the LIMIT-th tick occurs.
// Dropping run clears both the prescaler and the tick count.
module ub_wdog #(
  parameter int CLK_PER_TICK = 20,
  parameter int LIMIT        = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_TICK - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick   = (pre_q == PRE_MAX);
  assign expire = run && tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ub_status.sv
// Sticky timeout flags with write-one-to-clear strobes and interrupt output.
module ub_status (
  input  logic clk,
  input  logic rst,
  input  logic set_sel,
  input  logic set_ssyn,
  input  logic clr_sel,
  input  logic clr_ssyn,
  input  logic sel_ie,
  output logic sel_flag,
  output logic ssyn_flag,
  output logic irq
);
  logic sel_nxt, ssyn_nxt;

  // a set in the same cycle as a clear wins
  assign sel_nxt  = set_sel  || (sel_flag  && !clr_sel);
  assign ssyn_nxt = set_ssyn || (ssyn_flag && !clr_ssyn);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_flag  <= 1'b0;
      ssyn_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      sel_flag  <= sel_nxt;
      ssyn_flag <= ssyn_nxt;
      irq       <= sel_nxt && sel_ie;
    end
  end
endmodule

// File: rtl/ub_master_fsm.sv
// Transfer sequencer: acquire, setup, MSYN/SSYN handshake, completion.
module ub_master_fsm
  import ub_master_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_init,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_grant,
  input  logic              bbsy_in,
  input  logic              ssyn_in,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              sel_exp,
  input  logic              ssyn_exp,
  output logic              sel_run,
  output logic              ssyn_run,
  output logic              set_sel,
  output logic              set_ssyn,
  output logic              req_ready,
  output logic              bus_req,
  output logic              bbsy_out,
  output logic              msyn_out,
  output logic              wr_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout
);
  ub_state_e         state_q, state_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              write_q;
  logic              take_bus;

  // mastership only with grant and the bus left free by the last slave/master
  assign take_bus = bus_grant && !ssyn_in && !bbsy_in;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_nxt = ST_ARB;
      ST_ARB:   if (take_bus) state_nxt = ST_SETUP;
                else if (sel_exp) state_nxt = ST_TOUT;
      ST_SETUP: state_nxt = ST_MSYN;
      ST_MSYN:  if (ssyn_in) state_nxt = ST_DONE;
                else if (ssyn_exp) state_nxt = ST_TOUT;
      ST_DONE:  state_nxt = ST_IDLE;
      ST_TOUT:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || bus_init) state_q <= ST_IDLE;
    else                 state_q <= state_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (state_q == ST_IDLE && req_valid && !bus_init) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
      end
      if (state_q == ST_MSYN && ssyn_in)
        rdata_q <= write_q ? '0 : bus_din;
      else if (state_nxt == ST_TOUT)
        rdata_q <= '0;
    end
  end

  assign sel_run  = (state_q == ST_ARB)  && !bus_init;
  assign ssyn_run = (state_q == ST_MSYN) && !bus_init;
  assign set_sel  = (state_q == ST_ARB)  && !bus_init && !take_bus && sel_exp;
  assign set_ssyn = (state_q == ST_MSYN) && !bus_init && !ssyn_in && ssyn_exp;

  assign req_ready   = (state_q == ST_IDLE);
  assign bus_req     = (state_q == ST_ARB);
  assign bbsy_out    = (state_q == ST_SETUP) || (state_q == ST_MSYN);
  assign msyn_out    = (state_q == ST_MSYN);
  assign wr_out      = bbsy_out && write_q;
  assign addr_out    = addr_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_en = bbsy_out && write_q;
  assign rsp_valid   = (state_q == ST_DONE) || (state_q == ST_TOUT);
  assign rsp_rdata   = rsp_valid ? rdata_q : '0;
  assign rsp_timeout = (state_q == ST_TOUT);
endmodule

// File: rtl/ub_master_ctl.sv
// Top: sequencer, two watchdogs, status flags.
module ub_master_ctl
  import ub_master_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_PER_TICK = 20,
  parameter int SEL_TICKS    = 256,
  parameter int SSYN_TICKS   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_init,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              bbsy_in,
  input  logic              ssyn_in,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bbsy_out,
  output logic              msyn_out,
  output logic              wr_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic              sel_ie,
  input  logic              clr_sel_flag,
  input  logic              clr_ssyn_flag,
  output logic              sel_to_flag,
  output logic              ssyn_to_flag,
  output logic              irq
);
  logic [WD_NUM-1:0] wd_run, wd_exp;
  logic              set_sel, set_ssyn;

  for (genvar g = 0; g < WD_NUM; g++) begin : g_wdog
    localparam int LIM = (g == WD_SEL) ? SEL_TICKS : SSYN_TICKS;
    ub_wdog #(.CLK_PER_TICK(CLK_PER_TICK), .LIMIT(LIM)) u_wdog (
      .clk(clk), .rst(rst), .run(wd_run[g]), .expire(wd_exp[g])
    );
  end

  ub_master_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .bus_init(bus_init),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_grant(bus_grant), .bbsy_in(bbsy_in),
    .ssyn_in(ssyn_in), .bus_din(bus_din),
    .sel_exp(wd_exp[WD_SEL]), .ssyn_exp(wd_exp[WD_SSYN]),
    .sel_run(wd_run[WD_SEL]), .ssyn_run(wd_run[WD_SSYN]),
    .set_sel(set_sel), .set_ssyn(set_ssyn),
    .req_ready(req_ready), .bus_req(bus_req), .bbsy_out(bbsy_out),
    .msyn_out(msyn_out), .wr_out(wr_out), .addr_out(addr_out),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout)
  );

  ub_status u_status (
    .clk(clk), .rst(rst), .set_sel(set_sel), .set_ssyn(set_ssyn),
    .clr_sel(clr_sel_flag), .clr_ssyn(clr_ssyn_flag), .sel_ie(sel_ie),
    .sel_flag(sel_to_flag), .ssyn_flag(ssyn_to_flag), .irq(irq)
  );
endmodule

// File: rtl/ub_master_chk.sv
module ub_master_chk #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_PER_TICK = 20,
  parameter int SSYN_TICKS   = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_init,
  input logic              bus_grant,
  input logic              bbsy_in,
  input logic              ssyn_in,
  input logic              bbsy_out,
  input logic              msyn_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_timeout,
  input logic              sel_to_flag
);
  localparam int WIN = SSYN_TICKS * CLK_PER_TICK;
  int unsigned msyn_wait;

  always_ff @(posedge clk) begin
    if (rst || !msyn_out) msyn_wait <= 0;
    else if (!ssyn_in)    msyn_wait <= msyn_wait + 1;
  end

  assert_take_free_bus_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bbsy_out) |-> $past(bus_grant && !ssyn_in && !bbsy_in));
  assert_msyn_owner_R3: assert property (@(posedge clk) disable iff (rst)
    msyn_out |-> bbsy_out);
  assert_addr_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(msyn_out) |-> $past(bbsy_out) && $stable(addr_out));
  assert_rsp_after_msyn_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !msyn_out);
  assert_tout_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_timeout) |-> (rsp_rdata == '0));
  assert_sel_flag_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_to_flag) |-> (rsp_valid && rsp_timeout));
  assert_ssyn_window_R7: assert property (@(posedge clk) disable iff (rst)
    msyn_wait <= WIN);
  assert_init_abort_R10: assert property (@(posedge clk) disable iff (rst)
    bus_init |=> (!msyn_out && !bbsy_out && !rsp_valid));
endmodule

bind ub_master_ctl ub_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CLK_PER_TICK(CLK_PER_TICK), .SSYN_TICKS(SSYN_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .bus_init(bus_init), .bus_grant(bus_grant),
  .bbsy_in(bbsy_in), .ssyn_in(ssyn_in), .bbsy_out(bbsy_out),
  .msyn_out(msyn_out), .addr_out(addr_out), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout), .sel_to_flag(sel_to_flag)
);

// File: tb/test_ub_master_ctl.sv
`timescale 1ns/1ps
module test_ub_master_ctl;
  localparam int AW = 18, DW = 16;
  localparam int SEL_CYC  = 256 * 20;
  localparam int SSYN_CYC = 64 * 20;

  logic clk = 1'b0;
  logic rst = 1'b1, bus_init = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_timeout, bus_req;
  logic [DW-1:0] rsp_rdata;
  logic bus_grant = 1'b0, bbsy_in = 1'b0, ssyn_in = 1'b0;
  logic [DW-1:0] bus_din = '0;
  logic bbsy_out, msyn_out, wr_out, bus_dout_en;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] bus_dout;
  logic sel_ie = 1'b0, clr_sel_flag = 1'b0, clr_ssyn_flag = 1'b0;
  logic sel_to_flag, ssyn_to_flag, irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ub_master_ctl i_ub_master_ctl (
    .clk(clk), .rst(rst), .bus_init(bus_init), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .bus_req(bus_req), .bus_grant(bus_grant),
    .bbsy_in(bbsy_in), .ssyn_in(ssyn_in), .bus_din(bus_din),
    .bbsy_out(bbsy_out), .msyn_out(msyn_out), .wr_out(wr_out),
    .addr_out(addr_out), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .sel_ie(sel_ie), .clr_sel_flag(clr_sel_flag), .clr_ssyn_flag(clr_ssyn_flag),
    .sel_to_flag(sel_to_flag), .ssyn_to_flag(ssyn_to_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // waits at negedges until msyn_out is high; reports bbsy/addr one cycle earlier
  task automatic wait_msyn(output logic prev_bbsy, output logic [AW-1:0] prev_addr);
    prev_bbsy = 1'b0; prev_addr = '0;
    for (int i = 0; i < 20000 && !msyn_out; i++) begin
      prev_bbsy = bbsy_out; prev_addr = addr_out;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 bus_req", bus_req, 0);
    check("R1 bbsy_out", bbsy_out, 0);
    check("R1 msyn_out", msyn_out, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 flags", {sel_to_flag, ssyn_to_flag}, 0);
    check("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_read;
    logic pb; logic [AW-1:0] pa;
    bus_grant = 1'b1;
    issue(1'b0, 18'h2_1F00, 16'h0);
    wait_msyn(pb, pa);
    check("R3 bbsy before msyn", pb, 1);
    check("R3 addr stable before msyn", pa, 18'h2_1F00);
    check("R3 addr during msyn", addr_out, 18'h2_1F00);
    check("R3 read direction", wr_out, 0);
    ssyn_in = 1'b1; bus_din = 16'hA5C3;
    @(negedge clk);
    check("R4 msyn released", msyn_out, 0);
    check("R4 bbsy released", bbsy_out, 0);
    check("R4 rsp_valid", rsp_valid, 1);
    check("R4 rsp_rdata", rsp_rdata, 16'hA5C3);
    check("R4 rsp_timeout", rsp_timeout, 0);
    ssyn_in = 1'b0; bus_din = '0;
    @(negedge clk);
    check("R4 single pulse", rsp_valid, 0);
  endtask

  task automatic t_write;
    logic pb; logic [AW-1:0] pa;
    issue(1'b1, 18'h0_0400, 16'h1234);
    wait_msyn(pb, pa);
    check("R5 wr_out", wr_out, 1);
    check("R5 bus_dout_en", bus_dout_en, 1);
    check("R5 bus_dout", bus_dout, 16'h1234);
    ssyn_in = 1'b1; bus_din = 16'hFFFF;
    @(negedge clk);
    check("R5 rsp_valid", rsp_valid, 1);
    check("R5 rsp_rdata zero", rsp_rdata, 0);
    check("R5 rsp_timeout", rsp_timeout, 0);
    ssyn_in = 1'b0; bus_din = '0;
    @(negedge clk);
  endtask

  task automatic t_busy_other;
    logic pb; logic [AW-1:0] pa; int seen_bbsy = 0;
    bbsy_in = 1'b1;
    issue(1'b0, 18'h0_0010, 16'h0);
    for (int i = 0; i < 100; i++) begin
      if (bbsy_out) seen_bbsy++;
      @(negedge clk);
    end
    check("R2 waits while other BBSY", seen_bbsy, 0);
    check("R2 bus_req held", bus_req, 1);
    bbsy_in = 1'b0;
    wait_msyn(pb, pa);
    check("R2 takes bus after release", bbsy_out, 1);
    ssyn_in = 1'b1; bus_din = 16'h0042;
    @(negedge clk);
    check("R2 completes", rsp_rdata, 16'h0042);
    ssyn_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ssyn_timeout;
    logic pb; logic [AW-1:0] pa; int hi = 0;
    sel_ie = 1'b1;
    issue(1'b0, 18'h3_0000, 16'h0);
    wait_msyn(pb, pa);
    while (msyn_out && hi < 5000) begin hi++; @(negedge clk); end
    check("R7 msyn window", hi, SSYN_CYC);
    check("R7 bbsy released", bbsy_out, 0);
    check("R7 rsp_valid", rsp_valid, 1);
    check("R7 rsp_timeout", rsp_timeout, 1);
    check("R7 rsp_rdata zero", rsp_rdata, 0);
    @(negedge clk);
    check("R7 ssyn flag", ssyn_to_flag, 1);
    check("R7 sel flag untouched", sel_to_flag, 0);
    check("R8 ssyn flag gives no irq", irq, 0);
  endtask

  task automatic t_sel_timeout;
    int req_cyc = 0, took = 0;
    ssyn_in = 1'b1;   // slave left SSYN asserted
    issue(1'b0, 18'h0_0777, 16'h0);
    while (!rsp_valid && req_cyc < 20000) begin
      if (bus_req) req_cyc++;
      if (bbsy_out) took++;
      @(negedge clk);
    end
    check("R6 acquisition window", req_cyc, SEL_CYC);
    check("R6 never took bus", took, 0);
    check("R6 rsp_timeout", rsp_timeout, 1);
    check("R6 rsp_rdata zero", rsp_rdata, 0);
    check("R6 sel flag", sel_to_flag, 1);
    check("R8 irq with enable", irq, 1);
    ssyn_in = 1'b0;
    @(negedge clk);
    sel_ie = 1'b0;
    @(negedge clk);
    check("R8 irq follows enable", irq, 0);
    clr_ssyn_flag = 1'b1;
    @(negedge clk);
    clr_ssyn_flag = 1'b0;
    check("R9 ssyn flag cleared", ssyn_to_flag, 0);
    check("R9 sel flag kept", sel_to_flag, 1);
    clr_sel_flag = 1'b1;
    @(negedge clk);
    clr_sel_flag = 1'b0;
    check("R9 sel flag cleared", sel_to_flag, 0);
  endtask

  task automatic t_bus_init;
    logic pb; logic [AW-1:0] pa; int rsps = 0;
    issue(1'b0, 18'h0_1234, 16'h0);
    wait_msyn(pb, pa);
    bus_init = 1'b1;
    @(negedge clk);
    bus_init = 1'b0;
    check("R10 msyn dropped", msyn_out, 0);
    check("R10 bbsy dropped", bbsy_out, 0);
    check("R10 idle", req_ready, 1);
    for (int i = 0; i < 2000; i++) begin
      if (rsp_valid) rsps++;
      @(negedge clk);
    end
    check("R10 no response", rsps, 0);
    check("R10 no flags", {sel_to_flag, ssyn_to_flag}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_busy_other();
    t_ssyn_timeout();
    t_sel_timeout();
    t_bus_init();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule